// File: doc/BRIEF.md
# Paged EEPROM Write Buffer

This block sits between the serial-bus front end of an EEPROM model and the byte-wide storage array. A start command opens a page write at a 13-bit target address. Each byte that follows lands in a 32-entry slot buffer at the current in-page offset. Only the offset, the low five address bits, moves as bytes arrive, and it wraps inside the page. Nothing reaches the array until the stop-condition commit strobe arrives. The block then holds busy for a fixed write-cycle time. During that time it drains the filled slots to the array, one per cycle in ascending slot order. At the end of the busy time it empties the buffer.

Bytes enter on a valid/ready stream. A byte is taken on a clock edge where `load_valid` and `load_ready` are both high. The source may hold `load_valid` and its data for as long as it likes. `load_ready` is low while the block is busy and in any cycle that carries a start command. The memory write port has no back-pressure: the array takes one write on every cycle that `mem_we` is high. `start_valid`, `commit`, `wp`, `busy` and `last_addr` are plain level or strobe signals.

A write-protect level guards the top quarter of the 8 K-byte array, addresses 0x1800 to 0x1FFF. The block samples that level when the commit is taken.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` is 0, `mem_we` is 0, `load_ready` is 1 and `last_addr` is 0.
- R2: An accepted byte is stored at address {page, offset}, where page is `start_addr[12:5]` and offset begins at `start_addr[4:0]`. Each accepted byte advances only the offset by one. Page bits 12:5 never change during a page write.
- R3: When the offset steps past slot 31 it returns to slot 0 of the same page. A later byte for a slot that is already filled replaces the earlier byte, so the array receives only the last byte given to each slot.
- R4: No array write occurs before the commit. After a commit is taken, each filled slot is written once to {page, slot}, in ascending slot order, at one write per cycle. The writes fall within the busy interval.
- R5: A commit that is taken raises `busy` on the next clock edge. `busy` then stays high for exactly `WCYC_CYCLES` cycles.
- R6: While `busy` is high, `load_ready` is 0, and start, load and commit inputs have no effect. This is seen in `last_addr` and in the bytes written by later commits.
- R7: If `wp` is 1 when the commit is taken and the page lies in 0x1800 to 0x1FFF, no array write occurs, but `busy` still runs its full interval. If `wp` is 0, every address is written.
- R8: A start command empties the buffer, and so does the end of the busy interval. A commit with an empty buffer is ignored: `busy` stays 0 and nothing is written.
- R9: `last_addr` holds the full 13-bit address, {page, offset}, of the most recently accepted byte.
- R10: In a cycle with `start_valid` high, `load_ready` is 0 and the start takes effect. A byte presented in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Open a page write at `start_addr` |
| start_addr | input | 13 | Target address of the page write |
| load_valid | input | 1 | Byte offered on `load_data` |
| load_ready | output | 1 | Byte can be taken this cycle |
| load_data | input | 8 | Byte to buffer |
| commit | input | 1 | Stop condition: commit the buffered bytes |
| wp | input | 1 | Write-protect level for the upper quarter |
| busy | output | 1 | Internally timed write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |
| last_addr | output | 13 | Address of the most recently accepted byte |

## Verification
The assertions assume that the front end raises `commit` only as a single-cycle strobe, and that `WCYC_CYCLES` is larger than the page size, so the drain always finishes before `busy` falls. They take for granted that `wp` is meaningful only at the commit edge. The bench drives every input on the falling clock edge and pulses `start_valid` and `commit` for one cycle. It runs with a short write-cycle time that still exceeds 32 cycles. Tests that press commands during `busy` deliberately break the normal protocol, and the RTL must absorb these without breaking any property.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  parameter int ADDR_W     = 13;
  parameter int DATA_W     = 8;
  parameter int PAGE_BYTES = 32;
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int PAGE_W    = ADDR_W - OFF_W;

  // upper quarter of the array is the protectable region
  function automatic logic in_guard_zone(input logic [PAGE_W-1:0] page);
    return page[PAGE_W-1 -: 2] == 2'b11;
  endfunction
endpackage

// File: rtl/pwb_slots.sv
module pwb_slots
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clear_i,
  input  logic              busy_i,
  input  logic [OFF_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              any_valid_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [ADDR_W-1:0] last_addr_o
);
  logic [PAGE_W-1:0]     page_q;
  logic [OFF_W-1:0]      ptr_q;
  logic [ADDR_W-1:0]     last_q;
  logic [PAGE_BYTES-1:0] filled_q;
  logic [DATA_W-1:0]     byte_q [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      last_q <= '0;
    end else if (start_i) begin
      page_q <= start_addr_i[ADDR_W-1:OFF_W];
      ptr_q  <= start_addr_i[OFF_W-1:0];
    end else if (load_i) begin
      last_q <= {page_q, ptr_q};
      ptr_q  <= ptr_q + 1'b1;   // wraps inside the page
    end
  end

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filled_q[k] <= 1'b0;
        byte_q[k]   <= '0;
      end else if (start_i || clear_i) begin
        filled_q[k] <= 1'b0;
      end else if (load_i && ptr_q == OFF_W'(k)) begin
        filled_q[k] <= 1'b1;
        byte_q[k]   <= load_data_i;
      end
    end
  end

  assign rd_data_o   = byte_q[rd_idx_i];
  assign rd_valid_o  = filled_q[rd_idx_i];
  assign any_valid_o = |filled_q;
  assign page_o      = page_q;
  assign last_addr_o = last_q;

  assert_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !clear_i) |=> ($stable(filled_q) && $stable(page_q) && $stable(last_q)));
  assert_empty_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> (filled_q == '0));
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> $stable(page_q));
endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
  import pwb_pkg::*;
#(
  parameter int WCYC_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              any_valid_i,
  input  logic              wp_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [OFF_W-1:0]  rd_idx_o,
  output logic              busy_o,
  output logic              clear_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int CNT_W = $clog2(WCYC_CYCLES);

  logic             busy_q, wp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W:0]   scan_q;   // MSB set once every slot was visited
  logic             take, last_tick, locked;

  assign take      = commit_i && !busy_q && any_valid_i;
  assign last_tick = busy_q && (cnt_q == CNT_W'(WCYC_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wp_q   <= 1'b0;
      cnt_q  <= '0;
      scan_q <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      wp_q   <= wp_i;
      cnt_q  <= '0;
      scan_q <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (!scan_q[OFF_W]) scan_q <= scan_q + 1'b1;
      if (last_tick) busy_q <= 1'b0;
    end
  end

  assign locked      = wp_q && in_guard_zone(page_i);
  assign rd_idx_o    = scan_q[OFF_W-1:0];
  assign busy_o      = busy_q;
  assign clear_o     = last_tick;
  assign mem_we_o    = busy_q && !scan_q[OFF_W] && rd_valid_i && !locked;
  assign mem_addr_o  = {page_i, scan_q[OFF_W-1:0]};
  assign mem_wdata_o = rd_data_i;

  assert_write_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_q);
  assert_guard_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !(wp_q && mem_addr_o[ADDR_W-1 -: 2] == 2'b11));
  assert_busy_from_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(commit_i));
  assert_drain_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(scan_q[OFF_W]));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int WCYC_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [DATA_W-1:0] load_data,
  input  logic              commit,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] last_addr
);
  logic              start_acc, load_acc, clr, any_v, rd_v;
  logic [OFF_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_d;
  logic [PAGE_W-1:0] page;

  assign start_acc  = start_valid && !busy;
  assign load_ready = !busy && !start_valid;
  assign load_acc   = load_valid && load_ready;

  pwb_slots u_slots (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_acc), .start_addr_i(start_addr),
    .load_i(load_acc), .load_data_i(load_data),
    .clear_i(clr), .busy_i(busy),
    .rd_idx_i(rd_idx), .rd_data_o(rd_d), .rd_valid_o(rd_v),
    .any_valid_o(any_v), .page_o(page), .last_addr_o(last_addr)
  );

  pwb_sequencer #(.WCYC_CYCLES(WCYC_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit), .any_valid_i(any_v), .wp_i(wp), .page_i(page),
    .rd_valid_i(rd_v), .rd_data_i(rd_d), .rd_idx_o(rd_idx),
    .busy_o(busy), .clear_o(clr),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  assert_no_ready_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_ready);
endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
  localparam int WCYC = 40;
  // vector: {wp, first byte, count, start address}
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 8'h11, 6'd1,  13'h0040},
    {1'b0, 8'h20, 6'd6,  13'h013C},
    {1'b0, 8'h40, 6'd35, 13'h0205},
    {1'b1, 8'h60, 6'd3,  13'h1820},
    {1'b0, 8'h70, 6'd3,  13'h1820},
    {1'b1, 8'h80, 6'd3,  13'h17FE}
  };

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, load_valid = 0, commit = 0, wp = 0;
  logic [12:0] start_addr = '0;
  logic [7:0]  load_data = '0;
  logic load_ready, busy, mem_we;
  logic [12:0] mem_addr, last_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [12:0] wa [$];
  logic [7:0]  wd [$];

  always #10 clk = ~clk;

  page_write_buffer #(.WCYC_CYCLES(WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .commit(commit), .wp(wp), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .last_addr(last_addr)
  );

  always @(negedge clk) if (rst_n && mem_we) begin
    wa.push_back(mem_addr);
    wd.push_back(mem_wdata);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [12:0] a);
    @(negedge clk); start_valid = 1; start_addr = a;
    @(negedge clk); start_valid = 0;
  endtask

  task automatic do_loads(input int n, input logic [7:0] d0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); load_valid = 1; load_data = d0 + 8'(i);
    end
    @(negedge clk); load_valid = 0;
  endtask

  // pulse commit, return number of cycles busy stays high
  task automatic do_commit(output int len);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    len = 0;
    while (busy) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && mem_we == 0 && load_ready == 1 && last_addr == 0, "R1",
          {busy, mem_we, load_ready, 16'(last_addr)}, 32'h0010000);
    rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      logic [12:0] a; logic [7:0] d0; int n; logic pw;
      logic [7:0] ed [32]; bit ev [32]; int cnt; bit prot;
      a = VEC[v][12:0]; n = int'(VEC[v][18:13]); d0 = VEC[v][26:19]; pw = VEC[v][27];
      for (int s = 0; s < 32; s++) ev[s] = 0;
      for (int i = 0; i < n; i++) begin
        ed[(int'(a[4:0]) + i) % 32] = d0 + 8'(i);
        ev[(int'(a[4:0]) + i) % 32] = 1;
      end
      prot = pw && a[12:11] == 2'b11;
      wa.delete(); wd.delete();
      wp = pw;
      do_start(a);
      do_loads(n, d0);
      // R9 / R2 / R3 last accepted address, page fixed
      check(last_addr == {a[12:5], 5'((int'(a[4:0]) + n - 1) % 32)}, "R9 R2",
            last_addr, {a[12:5], 5'((int'(a[4:0]) + n - 1) % 32)});
      check(wa.size() == 0, "R4 no write before commit", wa.size(), 0);
      do_commit(len);
      check(len == WCYC, "R5 busy length", len, WCYC);
      cnt = 0;
      for (int s = 0; s < 32; s++) if (ev[s] && !prot) begin
        if (cnt < wa.size())
          check(wa[cnt] == {a[12:5], 5'(s)} && wd[cnt] == ed[s], "R3 R4 R7 write",
                {wa[cnt], 3'b0, wd[cnt]}, {a[12:5], 5'(s), 3'b0, ed[s]});
        cnt++;
      end
      check(wa.size() == cnt, "R4 R7 write count", wa.size(), cnt);
    end
    wp = 0;

    // R6 commands during busy are ignored
    wa.delete(); wd.delete();
    do_start(13'h0300); do_loads(1, 8'hA1);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    start_valid = 1; start_addr = 13'h0400; load_valid = 1; load_data = 8'hEE;
    #1 check(load_ready == 0, "R6 ready low in busy", load_ready, 0);
    @(negedge clk); commit = 1;
    @(negedge clk); start_valid = 0; load_valid = 0; commit = 0;
    while (busy) @(negedge clk);
    check(last_addr == 13'h0300, "R6 last_addr kept", last_addr, 13'h0300);
    check(wa.size() == 1 && wa[0] == 13'h0300 && wd[0] == 8'hA1, "R6 single write",
          {wa[0], 3'b0, wd[0]}, {13'h0300, 11'hA1});
    // R8 buffer emptied at end of busy: bare commit does nothing
    wa.delete(); wd.delete();
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    check(busy == 0, "R8 empty commit no busy", busy, 0);
    repeat (3) @(negedge clk);
    check(wa.size() == 0, "R8 empty commit no write", wa.size(), 0);

    // R8 start empties buffer
    do_start(13'h0500); do_loads(1, 8'h55);
    do_start(13'h0600);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    check(busy == 0, "R8 start clears slots", busy, 0);

    // R10 start wins over load in same cycle
    wa.delete(); wd.delete();
    @(negedge clk); start_valid = 1; start_addr = 13'h0700; load_valid = 1; load_data = 8'h77;
    #1 check(load_ready == 0, "R10 ready low on start", load_ready, 0);
    @(negedge clk); start_valid = 0; load_data = 8'h78;
    @(negedge clk); load_valid = 0;
    check(last_addr == 13'h0700, "R10 last_addr", last_addr, 13'h0700);
    do_commit(len);
    check(wa.size() == 1 && wa[0] == 13'h0700 && wd[0] == 8'h78, "R10 write",
          {wa[0], 3'b0, wd[0]}, {13'h0700, 11'h78});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule